// File: doc/BRIEF.md
# Hook, Handfree, Hold and Lock Controller

This controller sits in front of a telephone dialer and decides, every clock, whether the line is live for dialing. It watches a raw hook-switch input, an active-low handfree toggle input, a single-cycle hold-key strobe and a stream of decoded key strobes. From these it produces a handfree status output, a chip-enable flag, a hold flag that drives the hook mute, and a one-cycle key-accept pulse with the key code. Only accepted keys are passed on to the dialer.

The hook input is filtered by a clock-counting debounce. Its length depends on whether a lock policy is active. A two-bit lock setting picks one of three policies: open dialing, barring a leading 0, or barring a leading 0 or 9. When a barred digit arrives as the first key of a session, every later key is refused until the line is dropped. With a barring policy active, keys are also refused for a fixed delay after the line becomes enabled.

Top module: `hook_hf_lock_ctrl`

## Requirements
- R1: `hook_raw` high means on-hook. The filtered hook state follows `hook_raw` only after the input has held its new level for HOOK_DB_LOCK_MS*TICK_DIV clocks when `lock_mode` is not 2'b00, and for HOOK_DB_FREE_MS*TICK_DIV clocks when `lock_mode` is 2'b00. Shorter excursions are ignored.
- R2: `chip_en` is high when the filtered hook state is off-hook, or when `hf_out` is high. Otherwise it is low.
- R3: A falling edge on `hf_n` toggles `hf_out`. The toggle is registered on the third rising clock edge after the input falls. A rising edge on `hf_n` has no effect.
- R4: A `hold_key` strobe seen while `chip_en` is high toggles both `hold_on` and `hf_out`. A strobe seen while `chip_en` is low changes neither.
- R5: When an `hf_n` falling edge and an accepted hold strobe land in the same cycle, `hf_out` toggles once and `hold_on` toggles once.
- R6: A filtered hook transition from on-hook to off-hook clears `hf_out` and `hold_on`. `hold_on` is also cleared whenever `chip_en` goes low.
- R7: A key strobe is accepted only while `chip_en` is high and `hold_on` is low. `key_acc` pulses one cycle after the strobe, and `key_out` then carries the strobed code.
- R8: Lock policy encoding is: `lock_mode` 2'b00 for open dialing, 2'b01 to bar code 0, and 2'b10 or 2'b11 to bar codes 0 and 9. When the first eligible key of a session is a barred code, it is refused, and every later key is refused until `chip_en` goes low. A barred code that is not the first key is accepted.
- R9: With a barring policy, keys are refused for FIRST_KEY_DELAY_MS*TICK_DIV clocks after `chip_en` rises. Keys refused for this reason do not count as the first key of the session.
- R10: After reset, `hf_out`, `chip_en`, `hold_on` and `key_acc` are low, and the hook state is on-hook.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hook_raw | input | 1 | Raw hook switch, 1 = on-hook |
| hf_n | input | 1 | Active-low handfree toggle request |
| hold_key | input | 1 | One-cycle hold key strobe |
| key_stb | input | 1 | One-cycle decoded key strobe |
| key_code | input | KEY_W | Decoded key code (0 to 9 for digits) |
| lock_mode | input | 2 | Lock policy selection |
| hf_out | output | 1 | Handfree status |
| chip_en | output | 1 | Dialing enabled |
| hold_on | output | 1 | Hold state, drives the hook mute |
| key_acc | output | 1 | Key accepted pulse |
| key_out | output | KEY_W | Code of the last strobed key |

## Verification
Two sources can toggle the handfree state in the same cycle: the synchronised falling edge of `hf_n`, and an accepted hold strobe. The bench lowers `hf_n` and then raises `hold_key` two falling clock edges later. This places the hold strobe on the very rising edge that registers the handfree toggle. The outcome is judged against a single toggle: starting from low, `hf_out` and `hold_on` must both read high. A double toggle, or a lost event, leaves `hf_out` low.

// File: rtl/hhl_pkg.sv
package hhl_pkg;

  typedef enum logic [1:0] {
    LK_OPEN   = 2'b00,
    LK_BAR0   = 2'b01,
    LK_BAR09  = 2'b10,
    LK_BAR09B = 2'b11
  } lock_mode_e;

  function automatic logic lock_active(lock_mode_e m);
    return m != LK_OPEN;
  endfunction

  function automatic logic nine_barred(lock_mode_e m);
    return (m == LK_BAR09) || (m == LK_BAR09B);
  endfunction

endpackage

// File: rtl/hook_debounce.sv
module hook_debounce #(
  parameter int LOCK_CLKS = 600,
  parameter int FREE_CLKS = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic hook_raw,
  input  logic lock_on,
  output logic hook_q,
  output logic hook_fall
);

  localparam int MAXC = (LOCK_CLKS > FREE_CLKS) ? LOCK_CLKS : FREE_CLKS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOCK_END = CW'(LOCK_CLKS - 1);
  localparam logic [CW-1:0] FREE_END = CW'(FREE_CLKS - 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim = lock_on ? LOCK_END : FREE_END;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1        <= 1'b1;
      s2        <= 1'b1;
      hook_q    <= 1'b1;
      cnt       <= '0;
      hook_fall <= 1'b0;
    end else begin
      s1        <= hook_raw;
      s2        <= s1;
      hook_fall <= 1'b0;
      if (s2 == hook_q) begin
        cnt <= '0;
      end else if (cnt >= lim) begin
        hook_q    <= s2;
        hook_fall <= ~s2;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DB_FLIP_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (hook_q != $past(hook_q)) |-> (hook_q == $past(s2))); // R1

  AST_FALL_IS_OFFHOOK: assert property (@(posedge clk) disable iff (rst)
    hook_fall |-> !hook_q); // R6

endmodule

// File: rtl/hf_hold_fsm.sv
module hf_hold_fsm (
  input  logic clk,
  input  logic rst,
  input  logic hf_n,
  input  logic hold_key,
  input  logic hook_q,
  input  logic hook_fall,
  output logic hf_out,
  output logic chip_en,
  output logic hold_on
);

  logic h1, h2, h3;
  logic hf_edge, hold_ok, tog;
  logic hf_nxt, hold_nxt, en_nxt;

  assign hf_edge = h3 & ~h2;
  assign hold_ok = hold_key & chip_en;
  assign tog     = hf_edge | hold_ok;

  always_comb begin
    hf_nxt   = hook_fall ? 1'b0 : (hf_out ^ tog);
    hold_nxt = hook_fall ? 1'b0 : (hold_on ^ hold_ok);
    en_nxt   = ~hook_q | hf_nxt;
    if (!en_nxt) hold_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h1      <= 1'b1;
      h2      <= 1'b1;
      h3      <= 1'b1;
      hf_out  <= 1'b0;
      hold_on <= 1'b0;
      chip_en <= 1'b0;
    end else begin
      h1      <= hf_n;
      h2      <= h1;
      h3      <= h2;
      hf_out  <= hf_nxt;
      hold_on <= hold_nxt;
      chip_en <= en_nxt;
    end
  end

  AST_HOLD_FROM_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_on) |-> $past(hold_key)); // R4

  AST_HOOKFALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    hook_fall |=> (!hf_out && !hold_on)); // R6

endmodule

// File: rtl/key_gate.sv
module key_gate
  import hhl_pkg::*;
#(
  parameter int KEY_W = 4,
  parameter int DLY   = 1200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_stb,
  input  logic [KEY_W-1:0] key_code,
  input  lock_mode_e       mode,
  input  logic             chip_en,
  input  logic             hold_on,
  output logic             key_acc,
  output logic [KEY_W-1:0] key_out
);

  localparam int DW = $clog2(DLY + 1);
  localparam logic [DW-1:0] DLY_END = DW'(DLY - 1);
  localparam logic [KEY_W-1:0] CODE0 = KEY_W'(0);
  localparam logic [KEY_W-1:0] CODE9 = KEY_W'(9);

  logic [DW-1:0] dcnt;
  logic          delay_ok, first_done, locked;
  logic          lock_on, gate_ok, barred, first_bar;

  assign lock_on   = lock_active(mode);
  assign barred    = (key_code == CODE0) || (nine_barred(mode) && key_code == CODE9);
  assign first_bar = lock_on & ~first_done & barred;
  assign gate_ok   = chip_en & ~hold_on & ~locked & (delay_ok | ~lock_on);

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt       <= '0;
      delay_ok   <= 1'b0;
      first_done <= 1'b0;
      locked     <= 1'b0;
      key_acc    <= 1'b0;
      key_out    <= '0;
    end else begin
      if (key_stb) key_out <= key_code;
      if (!chip_en) begin
        dcnt       <= '0;
        delay_ok   <= 1'b0;
        first_done <= 1'b0;
        locked     <= 1'b0;
        key_acc    <= 1'b0;
      end else begin
        if (!delay_ok) begin
          if (dcnt == DLY_END) delay_ok <= 1'b1;
          else                 dcnt     <= dcnt + 1'b1;
        end
        key_acc <= key_stb & gate_ok & ~first_bar;
        if (key_stb && gate_ok) begin
          first_done <= 1'b1;
          if (first_bar) locked <= 1'b1;
        end
      end
    end
  end

  AST_ACC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    key_acc |-> ($past(chip_en) && !$past(hold_on))); // R7

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(locked) && $past(chip_en)) |-> locked); // R8

  AST_NO_ACC_LOCKED: assert property (@(posedge clk) disable iff (rst)
    key_acc |-> !$past(locked)); // R8

  AST_DELAY_BEFORE_ACC: assert property (@(posedge clk) disable iff (rst)
    (key_acc && $past(lock_on)) |-> $past(delay_ok)); // R9

endmodule

// File: rtl/hook_hf_lock_ctrl.sv
module hook_hf_lock_ctrl
  import hhl_pkg::*;
#(
  parameter int TICK_DIV           = 3580,
  parameter int HOOK_DB_LOCK_MS    = 150,
  parameter int HOOK_DB_FREE_MS    = 40,
  parameter int FIRST_KEY_DELAY_MS = 300,
  parameter int KEY_W              = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hook_raw,
  input  logic             hf_n,
  input  logic             hold_key,
  input  logic             key_stb,
  input  logic [KEY_W-1:0] key_code,
  input  logic [1:0]       lock_mode,
  output logic             hf_out,
  output logic             chip_en,
  output logic             hold_on,
  output logic             key_acc,
  output logic [KEY_W-1:0] key_out
);

  localparam int LOCK_CLKS = HOOK_DB_LOCK_MS * TICK_DIV;
  localparam int FREE_CLKS = HOOK_DB_FREE_MS * TICK_DIV;
  localparam int DLY_CLKS  = FIRST_KEY_DELAY_MS * TICK_DIV;

  lock_mode_e mode;
  logic       hook_q, hook_fall;

  assign mode = lock_mode_e'(lock_mode);

  hook_debounce #(
    .LOCK_CLKS(LOCK_CLKS),
    .FREE_CLKS(FREE_CLKS)
  ) u_db (
    .clk      (clk),
    .rst      (rst),
    .hook_raw (hook_raw),
    .lock_on  (lock_active(mode)),
    .hook_q   (hook_q),
    .hook_fall(hook_fall)
  );

  hf_hold_fsm u_hf (
    .clk      (clk),
    .rst      (rst),
    .hf_n     (hf_n),
    .hold_key (hold_key),
    .hook_q   (hook_q),
    .hook_fall(hook_fall),
    .hf_out   (hf_out),
    .chip_en  (chip_en),
    .hold_on  (hold_on)
  );

  key_gate #(
    .KEY_W(KEY_W),
    .DLY  (DLY_CLKS)
  ) u_kg (
    .clk     (clk),
    .rst     (rst),
    .key_stb (key_stb),
    .key_code(key_code),
    .mode    (mode),
    .chip_en (chip_en),
    .hold_on (hold_on),
    .key_acc (key_acc),
    .key_out (key_out)
  );

endmodule

// File: tb/sim_hook_hf_lock_ctrl.sv
`timescale 1ns/1ps
module sim_hook_hf_lock_ctrl;

  logic       clk = 1'b0;
  logic       rst, hook_raw, hf_n, hold_key, key_stb;
  logic [3:0] key_code;
  logic [1:0] lock_mode;
  logic       hf_out, chip_en, hold_on, key_acc;
  logic [3:0] key_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  // 4 clocks per ms: free debounce 16, lock debounce 60, first-key delay 120
  hook_hf_lock_ctrl #(
    .TICK_DIV(4), .HOOK_DB_LOCK_MS(15), .HOOK_DB_FREE_MS(4),
    .FIRST_KEY_DELAY_MS(30), .KEY_W(4)
  ) u0 (
    .clk(clk), .rst(rst), .hook_raw(hook_raw), .hf_n(hf_n), .hold_key(hold_key),
    .key_stb(key_stb), .key_code(key_code), .lock_mode(lock_mode),
    .hf_out(hf_out), .chip_en(chip_en), .hold_on(hold_on),
    .key_acc(key_acc), .key_out(key_out)
  );

  // op[8:7] (0 key, 1 handfree pulse, 2 hold), code[6:3], exp acc, hf, hold
  localparam logic [8:0] VECS [8] = '{
    {2'd0, 4'd5, 1'b1, 1'b0, 1'b0},
    {2'd0, 4'd0, 1'b1, 1'b0, 1'b0},
    {2'd1, 4'd0, 1'b0, 1'b1, 1'b0},
    {2'd2, 4'd0, 1'b0, 1'b0, 1'b1},
    {2'd0, 4'd3, 1'b0, 1'b0, 1'b1},
    {2'd2, 4'd0, 1'b0, 1'b1, 1'b0},
    {2'd0, 4'd9, 1'b1, 1'b1, 1'b0},
    {2'd1, 4'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] code, input logic exp, input string tag);
    @(negedge clk);
    key_stb  = 1'b1;
    key_code = code;
    @(negedge clk);
    key_stb = 1'b0;
    chk(tag, key_acc, exp);
    if (exp) chk({tag, " code"}, key_out == code, 1'b1);
    clks(2);
  endtask

  task automatic hf_pulse();
    @(negedge clk);
    hf_n = 1'b0;
    clks(3);
    hf_n = 1'b1;
    clks(6);
  endtask

  task automatic hold_press();
    @(negedge clk);
    hold_key = 1'b1;
    @(negedge clk);
    hold_key = 1'b0;
    clks(3);
  endtask

  task automatic wait_en();
    for (int i = 0; i < 400; i++) begin
      if (chip_en) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("[TB] FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; hook_raw = 1'b1; hf_n = 1'b1; hold_key = 1'b0;
    key_stb = 1'b0; key_code = '0; lock_mode = 2'b00;
    clks(5);
    rst = 1'b0;
    clks(2);
    chk("R10 hf_out", hf_out, 1'b0);
    chk("R10 chip_en", chip_en, 1'b0);
    chk("R10 hold_on", hold_on, 1'b0);
    chk("R10 key_acc", key_acc, 1'b0);

    // R1: short off-hook glitch, open policy
    @(negedge clk); hook_raw = 1'b0;
    clks(8); hook_raw = 1'b1;
    clks(30);
    chk("R1 glitch ignored", chip_en, 1'b0);

    // R2 R3: on-hook handfree dialing
    hf_pulse();
    chk("R3 hf toggles on", hf_out, 1'b1);
    chk("R2 enabled by hf", chip_en, 1'b1);
    press(4'd7, 1'b1, "R7 key on-hook hf");
    hold_press();
    chk("R4 hold toggles hf", hf_out, 1'b0);
    chk("R6 hold cleared on disable", hold_on, 1'b0);
    chk("R2 disabled", chip_en, 1'b0);
    hold_press();
    chk("R4 hold ignored disabled hf", hf_out, 1'b0);
    chk("R4 hold ignored disabled hold", hold_on, 1'b0);
    press(4'd7, 1'b0, "R7 key disabled");

    // off-hook
    @(negedge clk); hook_raw = 1'b0;
    clks(30);
    chk("R1 off-hook enables", chip_en, 1'b1);

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [8:0] e;
      e = VECS[v];
      case (e[8:7])
        2'd0: press(e[6:3], e[2], $sformatf("R7 vec%0d acc", v));
        2'd1: hf_pulse();
        default: hold_press();
      endcase
      chk($sformatf("R3 vec%0d hf", v), hf_out, e[1]);
      chk($sformatf("R4 vec%0d hold", v), hold_on, e[0]);
    end

    // R5: coincident handfree edge and hold strobe
    @(negedge clk); hf_n = 1'b0;
    @(negedge clk);
    @(negedge clk); hold_key = 1'b1;
    @(negedge clk); hold_key = 1'b0;
    clks(2); hf_n = 1'b1;
    clks(6);
    chk("R5 single hf toggle", hf_out, 1'b1);
    chk("R5 hold toggled", hold_on, 1'b1);
    hold_press();
    chk("R4 hold off hf", hf_out, 1'b0);
    chk("R4 hold off", hold_on, 1'b0);

    // R6: hook fall clears hold and handfree
    hold_press();
    chk("R4 hold on", hold_on, 1'b1);
    @(negedge clk); hook_raw = 1'b1;
    clks(30);
    chk("R2 on-hook kept by hf", chip_en, 1'b1);
    chk("R6 hold kept on-hook", hold_on, 1'b1);
    @(negedge clk); hook_raw = 1'b0;
    clks(30);
    chk("R6 hf cleared", hf_out, 1'b0);
    chk("R6 hold cleared", hold_on, 1'b0);
    chk("R2 off-hook enabled", chip_en, 1'b1);
    @(negedge clk); hook_raw = 1'b1;
    clks(30);
    chk("R2 on-hook disabled", chip_en, 1'b0);

    // R8 R9: bar 0 and 9
    lock_mode = 2'b10;
    @(negedge clk); hook_raw = 1'b0;
    wait_en();
    clks(100);
    press(4'd5, 1'b0, "R9 key during delay");
    clks(30);
    press(4'd9, 1'b0, "R8 first 9 barred");
    press(4'd5, 1'b0, "R8 locked out");
    @(negedge clk); hook_raw = 1'b1;
    clks(80);
    @(negedge clk); hook_raw = 1'b0;
    wait_en();
    clks(130);
    press(4'd3, 1'b1, "R8 new session first 3");
    press(4'd9, 1'b1, "R8 later 9 allowed");

    // R1: lock debounce is longer
    @(negedge clk); hook_raw = 1'b1;
    clks(80);
    chk("R1 on-hook lock", chip_en, 1'b0);
    @(negedge clk); hook_raw = 1'b0;
    clks(30); hook_raw = 1'b1;
    clks(80);
    chk("R1 lock glitch ignored", chip_en, 1'b0);

    // R8: bar 0 only
    lock_mode = 2'b01;
    @(negedge clk); hook_raw = 1'b0;
    wait_en();
    clks(130);
    press(4'd9, 1'b1, "R8 bar0 allows 9");
    press(4'd0, 1'b1, "R8 later 0 allowed");
    @(negedge clk); hook_raw = 1'b1;
    clks(80);
    @(negedge clk); hook_raw = 1'b0;
    wait_en();
    clks(130);
    press(4'd0, 1'b0, "R8 bar0 first 0");
    press(4'd4, 1'b0, "R8 bar0 locked");

    // R9: delayed rejection is not the first key
    @(negedge clk); hook_raw = 1'b1;
    clks(80);
    @(negedge clk); hook_raw = 1'b0;
    wait_en();
    clks(100);
    press(4'd0, 1'b0, "R9 0 during delay");
    clks(30);
    press(4'd4, 1'b1, "R9 first after delay");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule